// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the run of column addresses that a synchronous DRAM controller steps through during one read or write burst. A request gives a start column, a length code and an ordering mode, and is marked by a one-cycle start strobe. The block then presents one column address per clock, starting in the strobe's own cycle. It raises a valid flag for every beat and a last flag on the final beat.

Only the address bits inside a window the size of the burst change during the burst. The window is aligned to the burst length. Two orderings are available: an upward count that wraps inside the window, and an interleaved order in which each beat's low bits are the start offset XORed with the beat number. Column bits above the window keep their start value for the whole burst. The length code and ordering mode are sampled only in the cycle that starts a burst. Strobes that arrive while a burst is running are dropped. A strobe in the cycle right after the final beat opens the next burst with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: The length code `len_code_i` selects the burst length: 2'b00 gives 2 beats, 2'b01 gives 4 beats, and 2'b10 and 2'b11 both give 8 beats. `beat_vld_o` is high for exactly that many consecutive cycles per accepted burst.
- R2: An accepted start shows its first address in the strobe's own cycle, with `beat_vld_o` high and `col_o` equal to `start_col_i` in both orderings.
- R3: With `order_i` = 0 (sequential), the low window bits of beat k equal (start offset + k) modulo the burst length. Example: length 4 starting at 2 gives 2, 3, 0, 1.
- R4: With `order_i` = 1 (interleaved), the low window bits of beat k equal the start offset XOR k. Example: length 8 starting at 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R5: Column bits above the window (bit 1 and up for length 2, bit 2 and up for length 4, bit 3 and up for length 8) equal the start column's bits on every beat.
- R6: `beat_last_o` is high only on the final beat of a burst, and only together with `beat_vld_o`.
- R7: A start strobe during beats 1 to L-1 of a running burst, including the final beat, is ignored. The running burst's addresses, length and last beat are unchanged, and no extra beat follows.
- R8: A start strobe in the cycle right after the final beat begins a new burst in that same cycle, with no idle cycle between the two bursts.
- R9: While `rst_n` is low, `beat_vld_o` and `beat_last_o` are low and any running burst is abandoned. After release the block stays idle until a new start strobe.
- R10: With a start offset of zero, both orderings give the ascending run 0, 1, …, L-1 in the window bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Burst start strobe, one cycle |
| start_col_i | input | COL_W | Start column address |
| len_code_i | input | 2 | Burst length code (00:2, 01:4, 10/11:8) |
| order_i | input | 1 | Ordering mode (0 sequential, 1 interleaved) |
| col_o | output | COL_W | Column address of the current beat (zero when no beat) |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the last of its burst |

## Verification
Two functions can fall in the same cycle: the final beat of a running burst and the arrival of a start strobe. The bench drives a strobe with unrelated column, length and mode values on every beat after the first, including the final beat. It checks that the running sequence, its last flag and its length are untouched. It then drives a real strobe in the very next cycle and checks that the new burst's first address appears at once, so the block must tell a strobe on the last beat (dropped) apart from one on the following cycle (taken).

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Ordering mode of a burst
  typedef enum logic {
    ORDER_SEQ   = 1'b0,
    ORDER_INTLV = 1'b1
  } order_e;

  // Width of the length code
  localparam int unsigned LEN_CODE_W = 2;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int unsigned BEAT_W = 3
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  output logic [BEAT_W-1:0]     win_mask_o
);

  localparam int unsigned MAX_CODE = BEAT_W - 1;

  int unsigned eff_code;

  // Codes beyond the longest supported burst fold onto the longest one
  always_comb begin
    if (int'(len_code_i) > int'(MAX_CODE)) begin
      eff_code = MAX_CODE;
    end else begin
      eff_code = int'(len_code_i);
    end
  end

  // Window mask: ones on the low (code+1) bits, i.e. burst length - 1
  for (genvar g = 0; g < BEAT_W; g++) begin : g_mask
    assign win_mask_o[g] = (g <= eff_code);
  end

endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned BEAT_W = 3
) (
  input  logic [BEAT_W-1:0] base_low_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BEAT_W-1:0] win_mask_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] offset_o
);

  logic [BEAT_W-1:0] seq_sum;
  logic [BEAT_W-1:0] intlv_val;

  always_comb begin
    seq_sum   = base_low_i + beat_i;
    intlv_val = base_low_i ^ beat_i;
    if (order_i == ORDER_INTLV) begin
      offset_o = intlv_val & win_mask_i;
    end else begin
      offset_o = seq_sum & win_mask_i;
    end
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] new_mask_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [BEAT_W-1:0] cur_beat_o,
  output logic [BEAT_W-1:0] cur_mask_o,
  output logic              active_o,
  output logic              last_o
);

  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] mask_q, mask_d;
  logic              beat_en;
  logic              mask_en;

  // A strobe is taken only when no burst is running and reset is released
  assign accept_o   = start_i & ~busy_q & rst_n;
  assign busy_o     = busy_q;
  assign active_o   = accept_o | busy_q;
  assign cur_beat_o = busy_q ? beat_q : '0;
  assign cur_mask_o = busy_q ? mask_q : new_mask_i;
  assign last_o     = active_o & (cur_beat_o == cur_mask_o);

  // Next-state logic
  always_comb begin
    busy_d  = busy_q;
    beat_d  = beat_q;
    mask_d  = mask_q;
    beat_en = 1'b0;
    mask_en = 1'b0;
    if (accept_o) begin
      busy_d  = ~last_o;
      beat_d  = {{(BEAT_W-1){1'b0}}, 1'b1};
      mask_d  = new_mask_i;
      beat_en = 1'b1;
      mask_en = 1'b1;
    end else if (busy_q) begin
      if (last_o) begin
        busy_d = 1'b0;
      end else begin
        beat_d  = beat_q + 1'b1;
        beat_en = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  // Assertions
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && beat_q == $past(beat_q) + 1'b1)); // R1

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_q && beat_q == {{(BEAT_W-1){1'b0}}, 1'b1})); // R2

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last_o) |=> !busy_q); // R8

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> $stable(mask_q)); // R7

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BEAT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  beat_vld_o,
  output logic                  beat_last_o
);

  localparam int unsigned UP_W = COL_W - BEAT_W;

  logic [BEAT_W-1:0] new_mask;
  logic              accept;
  logic              busy;
  logic [BEAT_W-1:0] cur_beat;
  logic [BEAT_W-1:0] cur_mask;
  logic              active;
  logic              last;
  logic [BEAT_W-1:0] offset;

  logic [COL_W-1:0]  base_q, base_d;
  order_e            order_q, order_d;
  logic              cap_en;

  logic [COL_W-1:0]  base_now;
  order_e            order_now;
  logic [COL_W-1:0]  win_full;
  logic [COL_W-1:0]  col_raw;

  burst_len_decode #(
    .BEAT_W (BEAT_W)
  ) i_len_decode (
    .len_code_i (len_code_i),
    .win_mask_o (new_mask)
  );

  burst_beat_ctrl #(
    .BEAT_W (BEAT_W)
  ) i_beat_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .new_mask_i (new_mask),
    .accept_o   (accept),
    .busy_o     (busy),
    .cur_beat_o (cur_beat),
    .cur_mask_o (cur_mask),
    .active_o   (active),
    .last_o     (last)
  );

  // Burst parameters come from the inputs in the start cycle, from the
  // captured copy afterwards
  assign base_now  = busy ? base_q : start_col_i;
  assign order_now = busy ? order_q : order_e'(order_i);

  burst_offset_gen #(
    .BEAT_W (BEAT_W)
  ) i_offset_gen (
    .base_low_i (base_now[BEAT_W-1:0]),
    .beat_i     (cur_beat),
    .win_mask_i (cur_mask),
    .order_i    (order_now),
    .offset_o   (offset)
  );

  // Capture next-state
  always_comb begin
    cap_en  = accept;
    base_d  = start_col_i;
    order_d = order_e'(order_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORDER_SEQ;
    end else if (cap_en) begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  // Per-bit merge: window bits from the offset, the rest from the base
  assign win_full = {{UP_W{1'b0}}, cur_mask};

  for (genvar g = 0; g < COL_W; g++) begin : g_merge
    if (g < BEAT_W) begin : g_low
      assign col_raw[g] = cur_mask[g] ? offset[g] : base_now[g];
    end else begin : g_high
      assign col_raw[g] = base_now[g];
    end
  end

  assign col_o       = active ? col_raw : '0;
  assign beat_vld_o  = active;
  assign beat_last_o = last;

  // Assertions
  AST_FIRST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (col_o == start_col_i)); // R2

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((col_o ^ $past(col_o)) & ~win_full) == '0)); // R5

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_vld_o); // R6

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_last_o) |=> ($stable(base_q) && $stable(order_q))); // R7

  AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !beat_last_o) |=> beat_vld_o); // R1

endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  localparam int unsigned COL_W = 10;
  localparam realtime     HALF  = 2.5ns;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [1:0]       len_code_i;
  logic             order_i;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o;
  logic             beat_last_o;

  int checks;
  int errors;

  burst_col_seq #(
    .COL_W  (COL_W),
    .BEAT_W (3)
  ) i_burst_col_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .order_i     (order_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .beat_last_o (beat_last_o)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t",
               req, what, act, exp, $time);
    end
  endtask

  function automatic int unsigned len_of(input logic [1:0] code);
    return (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input logic [1:0] code, input logic ord, input int unsigned k);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] lo;
    m = COL_W'(len_of(code) - 1);
    if (ord) lo = ((s & m) ^ COL_W'(k)) & m;
    else     lo = ((s & m) + COL_W'(k)) & m;
    return (s & ~m) | lo;
  endfunction

  // One full burst; req names the ordering requirement checked on col_o.
  // junk drives stray strobes with unrelated inputs on beats 1..L-1.
  task automatic run_burst(input string req, input logic [COL_W-1:0] s,
                           input logic [1:0] code, input logic ord,
                           input bit junk);
    int unsigned len;
    len = len_of(code);
    for (int k = 0; k < int'(len); k++) begin
      @(negedge clk);
      if (k == 0) begin
        start_i     = 1'b1;
        start_col_i = s;
        len_code_i  = code;
        order_i     = ord;
      end else begin
        start_i     = junk;
        start_col_i = ~s;
        len_code_i  = ~code;
        order_i     = ~ord;
      end
      #1;
      check(k == 0 ? "R2" : req, "col", 32'(col_o),
            32'(exp_col(s, code, ord, k)));
      check("R1", "valid", 32'(beat_vld_o), 32'd1);
      check("R6", "last", 32'(beat_last_o), (k == int'(len) - 1) ? 32'd1 : 32'd0);
      if (junk && k > 0) check("R7", "col under stray strobe", 32'(col_o),
                               32'(exp_col(s, code, ord, k)));
      if (k > 0) check("R5", "upper bits", 32'(col_o >> $clog2(len)),
                       32'(s >> $clog2(len)));
    end
  endtask

  task automatic idle_cycles(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      #1;
      check(req, "idle valid", 32'(beat_vld_o), 32'd0);
      check(req, "idle last", 32'(beat_last_o), 32'd0);
    end
  endtask

  task automatic t_reset_state();
    #1;
    check("R9", "valid in reset", 32'(beat_vld_o), 32'd0);
    check("R9", "last in reset", 32'(beat_last_o), 32'd0);
    @(negedge clk);
    start_i = 1'b1;
    #1;
    check("R9", "strobe in reset", 32'(beat_vld_o), 32'd0);
    @(negedge clk);
    start_i = 1'b0;
    rst_n   = 1'b1;
    idle_cycles("R9", 2);
  endtask

  task automatic t_sequential();
    run_burst("R3", 10'h3A2, 2'b01, 1'b0, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R3", 10'h2C6, 2'b10, 1'b0, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R3", 10'h155, 2'b00, 1'b0, 1'b0);
    idle_cycles("R1", 1);
  endtask

  task automatic t_interleaved();
    run_burst("R4", 10'h0F5, 2'b10, 1'b1, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R4", 10'h1E3, 2'b01, 1'b1, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R4", 10'h201, 2'b00, 1'b1, 1'b0);
    idle_cycles("R1", 1);
  endtask

  task automatic t_zero_offset();
    run_burst("R10", 10'h2F8, 2'b10, 1'b0, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R10", 10'h2F8, 2'b10, 1'b1, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R10", 10'h104, 2'b01, 1'b1, 1'b0);
    idle_cycles("R1", 1);
  endtask

  task automatic t_code_alias();
    run_burst("R1", 10'h3CB, 2'b11, 1'b0, 1'b0);
    idle_cycles("R1", 1);
    run_burst("R1", 10'h3CB, 2'b11, 1'b1, 1'b0);
    idle_cycles("R1", 1);
  endtask

  task automatic t_stray_and_chain();
    // Stray strobes on every later beat, then a chained burst at once
    run_burst("R7", 10'h06E, 2'b10, 1'b1, 1'b1);
    run_burst("R8", 10'h333, 2'b00, 1'b0, 1'b1);
    run_burst("R8", 10'h0AA, 2'b01, 1'b1, 1'b1);
    run_burst("R8", 10'h3FF, 2'b10, 1'b0, 1'b0);
    idle_cycles("R7", 2);
  endtask

  task automatic t_reset_mid_burst();
    @(negedge clk);
    start_i     = 1'b1;
    start_col_i = 10'h123;
    len_code_i  = 2'b10;
    order_i     = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R3", "pre-reset col", 32'(col_o), 32'(exp_col(10'h123, 2'b10, 1'b0, k)));
      @(negedge clk);
      start_i = 1'b0;
    end
    rst_n = 1'b0;
    #1;
    check("R9", "valid after reset assert", 32'(beat_vld_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles("R9", 6);
    run_burst("R3", 10'h123, 2'b01, 1'b0, 1'b0);
    idle_cycles("R1", 1);
  endtask

  initial begin
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    start_i     = 1'b0;
    start_col_i = '0;
    len_code_i  = 2'b00;
    order_i     = 1'b0;
    t_reset_state();
    t_sequential();
    t_interleaved();
    t_zero_offset();
    t_code_alias();
    t_stray_and_chain();
    t_reset_mid_burst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule